// File: doc/BRIEF.md
# Per-Core Coherence Statistics Profiler

This block sits next to one processor core and gathers three running statistics while a sampling window is open: how many memory accesses the core made, how many of those accesses target data whose home tile is a different tile, and the total latency of all L2 misses that completed. At the end of the window, a chip-level aggregator reads the three values. It uses them to estimate the average memory latency under each coherence scheme and to decide whether switching schemes is worthwhile.

The block has no coherence-mode input. Remote-home accesses are counted even while the core runs in directory mode and never actually sends a remote request, so the cost of the shared-cache mode can be predicted before that mode is ever turned on. The block only observes strobes and never stalls the core.

The counters update only while the sampling flag is high and hold their values afterwards. Mapping a new thread or application onto the core clears them. Every register saturates at all-ones instead of wrapping.

Top module: `coh_stat_profiler`

## Requirements
- R1: After reset, all three statistics and the read port output are zero.
- R2: While sampleEn is high and threadSwap is low, each cycle with accValid high raises accCount by exactly one.
- R3: In such a cycle, coreMissCount also rises by one when homeCore differs from localCore. It does not change when they are equal. No coherence mode affects this rule.
- R4: While sampleEn is high and threadSwap is low, each cycle with missDone high adds missLat to latSum.
- R5: While sampleEn is low and threadSwap is low, all three statistics hold their value whatever the event inputs do.
- R6: threadSwap high clears all three statistics at the next edge, regardless of sampleEn. It takes priority over any event in the same cycle.
- R7: accCount and coreMissCount stop at all-ones and never wrap.
- R8: When the sum would exceed all-ones, latSum saturates at all-ones.
- R9: An access and an L2-miss completion in the same cycle are both recorded in that cycle.
- R10: rdData is combinational and depends on rdSel: 0 selects accCount, 1 selects coreMissCount, 2 selects latSum, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| threadSwap | input | 1 | New thread or application mapped; clears statistics |
| sampleEn | input | 1 | Sampling window open |
| accValid | input | 1 | One memory access this cycle |
| homeCore | input | CORE_W | Home tile of the access, from translation |
| localCore | input | CORE_W | Tile the thread runs on |
| missDone | input | 1 | An L2 miss completed this cycle |
| missLat | input | LAT_W | Measured latency of the completing miss |
| rdSel | input | 2 | Read port select |
| accCount | output | CNT_W | Access count |
| coreMissCount | output | CNT_W | Remote-home access count |
| latSum | output | CNT_W | Accumulated L2 miss latency |
| rdData | output | CNT_W | Selected statistic |

## Verification
Several properties are checked on every cycle. The statistics hold outside the window with no swap pending. A swap empties every register one edge later. No register ever decreases unless it is cleared. The remote-home count never exceeds the access count. The zero read select returns zero. The exact arithmetic can only be shown by the bench scenarios: increments of one, per-access comparison of home and local tile IDs, latency addition, the exact saturation point, and simultaneous events. The bench sweeps every pair of tile IDs and every latency value on a narrow configuration, and compares each result against a model it computes itself.

// File: rtl/coh_prof_pkg.sv
package coh_prof_pkg;

  typedef struct packed {
    logic clr;
    logic incAcc;
    logic incCoreMiss;
    logic addLat;
  } profStrobe_t;

  typedef enum logic [1:0] {
    SEL_ACC   = 2'd0,
    SEL_CMISS = 2'd1,
    SEL_LAT   = 2'd2,
    SEL_NONE  = 2'd3
  } rdSel_e;

  localparam int NUM_STATS = 3;

endpackage

// File: rtl/prof_sat_accum.sv
module prof_sat_accum #(
  parameter int W    = 64,
  parameter int IN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [IN_W-1:0] addend,
  output logic [W-1:0]    total
);
  logic [W:0]   sumWide;
  logic [W-1:0] nextVal;

  always_comb begin
    sumWide = {1'b0, total} + (W+1)'(addend);
    nextVal = sumWide[W] ? {W{1'b1}} : sumWide[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   total <= '0;
    else if (clr) total <= '0;
    else if (en)  total <= nextVal;
  end
endmodule

// File: rtl/prof_ctrl.sv
module prof_ctrl
  import coh_prof_pkg::*;
#(
  parameter int CORE_W = 7
) (
  input  logic              threadSwap,
  input  logic              sampleEn,
  input  logic              accValid,
  input  logic [CORE_W-1:0] homeCore,
  input  logic [CORE_W-1:0] localCore,
  input  logic              missDone,
  output profStrobe_t       strb
);
  logic live;
  logic remoteHome;

  always_comb begin
    live             = sampleEn && !threadSwap;
    remoteHome       = (homeCore != localCore);
    strb.clr         = threadSwap;
    strb.incAcc      = live && accValid;
    strb.incCoreMiss = live && accValid && remoteHome;
    strb.addLat      = live && missDone;
  end
endmodule

// File: rtl/prof_dpath.sv
module prof_dpath
  import coh_prof_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  profStrobe_t       strb,
  input  logic [LAT_W-1:0]  missLat,
  input  logic [1:0]        rdSel,
  output logic [CNT_W-1:0]  accCnt,
  output logic [CNT_W-1:0]  coreMissCnt,
  output logic [CNT_W-1:0]  latTotal,
  output logic [CNT_W-1:0]  rdData
);
  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [NUM_STATS-1:0] enVec;
  logic [LAT_W-1:0]     addVec [NUM_STATS];
  logic [CNT_W-1:0]     totVec [NUM_STATS];

  always_comb begin
    enVec[0]  = strb.incAcc;
    enVec[1]  = strb.incCoreMiss;
    enVec[2]  = strb.addLat;
    addVec[0] = ONE;
    addVec[1] = ONE;
    addVec[2] = missLat;
  end

  for (genvar g = 0; g < NUM_STATS; g++) begin : gStat
    prof_sat_accum #(.W(CNT_W), .IN_W(LAT_W)) uAcc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (strb.clr),
      .en     (enVec[g]),
      .addend (addVec[g]),
      .total  (totVec[g])
    );
  end

  assign accCnt      = totVec[0];
  assign coreMissCnt = totVec[1];
  assign latTotal    = totVec[2];

  always_comb begin
    case (rdSel_e'(rdSel))
      SEL_ACC:   rdData = totVec[0];
      SEL_CMISS: rdData = totVec[1];
      SEL_LAT:   rdData = totVec[2];
      default:   rdData = '0;
    endcase
  end

  AST_ACC_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clr |=> accCnt >= $past(accCnt)); // R7
  AST_CMISS_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clr |=> coreMissCnt >= $past(coreMissCnt)); // R7
  AST_LAT_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clr |=> latTotal >= $past(latTotal)); // R8
  AST_MISS_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    coreMissCnt <= accCnt); // R3
  AST_RD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    rdSel == 2'd3 |-> rdData == '0); // R10
endmodule

// File: rtl/coh_stat_profiler.sv
module coh_stat_profiler
  import coh_prof_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int LAT_W  = 16,
  parameter int CORE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              threadSwap,
  input  logic              sampleEn,
  input  logic              accValid,
  input  logic [CORE_W-1:0] homeCore,
  input  logic [CORE_W-1:0] localCore,
  input  logic              missDone,
  input  logic [LAT_W-1:0]  missLat,
  input  logic [1:0]        rdSel,
  output logic [CNT_W-1:0]  accCount,
  output logic [CNT_W-1:0]  coreMissCount,
  output logic [CNT_W-1:0]  latSum,
  output logic [CNT_W-1:0]  rdData
);
  profStrobe_t strb;

  prof_ctrl #(.CORE_W(CORE_W)) uCtrl (
    .threadSwap (threadSwap),
    .sampleEn   (sampleEn),
    .accValid   (accValid),
    .homeCore   (homeCore),
    .localCore  (localCore),
    .missDone   (missDone),
    .strb       (strb)
  );

  prof_dpath #(.CNT_W(CNT_W), .LAT_W(LAT_W)) uDpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .missLat     (missLat),
    .rdSel       (rdSel),
    .accCnt      (accCount),
    .coreMissCnt (coreMissCount),
    .latTotal    (latSum),
    .rdData      (rdData)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleEn && !threadSwap) |=> ($stable(accCount) && $stable(coreMissCount) && $stable(latSum))); // R5
  AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    threadSwap |=> (accCount == '0 && coreMissCount == '0 && latSum == '0)); // R6
endmodule

// File: tb/sim_coh_stat_profiler.sv
module sim_coh_stat_profiler;
  localparam int CNT_W = 8;
  localparam int LAT_W = 6;
  localparam int CORE_W = 3;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic threadSwap = 1'b0, sampleEn = 1'b0, accValid = 1'b0, missDone = 1'b0;
  logic [CORE_W-1:0] homeCore = '0, localCore = '0;
  logic [LAT_W-1:0] missLat = '0;
  logic [1:0] rdSel = '0;
  logic [CNT_W-1:0] accCount, coreMissCount, latSum, rdData;

  int total = 0, bad = 0;
  int eAcc = 0, eMiss = 0, eLat = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  coh_stat_profiler #(.CNT_W(CNT_W), .LAT_W(LAT_W), .CORE_W(CORE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .threadSwap(threadSwap), .sampleEn(sampleEn),
    .accValid(accValid), .homeCore(homeCore), .localCore(localCore),
    .missDone(missDone), .missLat(missLat), .rdSel(rdSel),
    .accCount(accCount), .coreMissCount(coreMissCount), .latSum(latSum), .rdData(rdData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " acc"}, int'(accCount), eAcc);
    chk({tag, " cmiss"}, int'(coreMissCount), eMiss);
    chk({tag, " lat"}, int'(latSum), eLat);
  endtask

  task automatic step(input logic en, input logic sw, input logic av,
                      input int hc, input int lc, input logic md, input int lt);
    @(negedge clk);
    sampleEn = en; threadSwap = sw; accValid = av;
    homeCore = CORE_W'(hc); localCore = CORE_W'(lc);
    missDone = md; missLat = LAT_W'(lt);
    if (sw) begin
      eAcc = 0; eMiss = 0; eLat = 0;
    end else if (en) begin
      if (av && eAcc < MAXV) eAcc++;
      if (av && hc != lc && eMiss < MAXV) eMiss++;
      if (md) eLat = (eLat + lt > MAXV) ? MAXV : eLat + lt;
    end
    @(posedge clk);
    #1;
    accValid = 0; missDone = 0; threadSwap = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset");
    for (int s = 0; s < 4; s++) begin
      rdSel = 2'(s); #1; chk("R1 rdData", int'(rdData), 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R3: every pair of tile IDs
    for (int h = 0; h < 8; h++)
      for (int l = 0; l < 8; l++) begin
        step(1, 0, 1, h, l, 0, 0);
        checkAll("R2 R3 sweep");
      end

    // R4 R8: every latency value, saturating latSum
    step(0, 1, 0, 0, 0, 0, 0); checkAll("R6 clear");
    for (int v = 0; v < 64; v++) begin
      step(1, 0, 0, 0, 0, 1, v);
      checkAll("R4 R8 latency");
    end

    // R9 simultaneous events
    step(0, 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 1, k, 3, 1, k + 5);
      checkAll("R9 both");
    end

    // R5 idle window with event activity
    for (int k = 0; k < 10; k++) begin
      step(0, 0, 1, 1, 2, 1, 17);
      checkAll("R5 hold");
    end

    // R6 swap with concurrent events, sampleEn high and low
    step(1, 1, 1, 1, 2, 1, 30); checkAll("R6 swap prio");
    step(1, 0, 1, 4, 0, 1, 9);  checkAll("R6 after");
    step(0, 1, 1, 4, 0, 1, 9);  checkAll("R6 swap idle");

    // R10 read port
    step(1, 0, 1, 2, 5, 1, 40);
    step(1, 0, 1, 5, 5, 0, 0);
    for (int s = 0; s < 4; s++) begin
      rdSel = 2'(s); #1;
      chk("R10 rdSel", int'(rdData), s == 0 ? eAcc : s == 1 ? eMiss : s == 2 ? eLat : 0);
    end

    // R7 counter saturation
    for (int k = 0; k < 300; k++) begin
      step(1, 0, 1, k % 8, 0, 0, 0);
      checkAll("R7 sat");
    end
    rdSel = 2'd0; #1; chk("R7 rd acc", int'(rdData), MAXV);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule